// File: doc/BRIEF.md
# Unaligned Word Load Splitter

This block takes 32-bit load requests from a load/store pipeline at any byte address and serves them from a memory that can only deliver whole, aligned 32-bit words. A request whose two low address bits are zero becomes one word read, and the returned word goes straight to the result. Any other request becomes two word reads, at word index N and then at N+1. The block rotates the returned byte lanes and merges the two words into the requested little-endian word.

The memory side uses a one-cycle read strobe with a word address. It answers each strobe with a one-cycle valid and data after a fixed latency. The pipeline side sees a ready flag that is high only while the block is idle. Each finished load produces a one-cycle done pulse, and the merged word appears on the same cycle.

Top module: `split_load_merger`

## Requirements
- R1: After synchronous reset, req_ready is 1, and done and mem_rd_en are 0.
- R2: A request whose byte address has bits [1:0] equal to 0 causes exactly one mem_rd_en pulse, with mem_word_addr equal to address bits [ADDR_W-1:2]. The result equals the returned word unchanged.
- R3: A request whose byte address has non-zero bits [1:0] causes exactly two mem_rd_en pulses. The first carries word index N = address bits [ADDR_W-1:2]. The second carries N+1 and is issued only after the first read has returned.
- R4: For offset k = address bits [1:0], byte lanes k..3 of the first returned word (lane j is bits 8j+7:8j) appear in result lanes 0..3-k. The byte at the lowest address lands in result bits 7:0.
- R5: For offset k, byte lanes 0..k-1 of the second returned word appear in result lanes 4-k..3.
- R6: When N is the largest word index, the second read uses word index 0.
- R7: While a load is in progress, req_ready is 0, and requests offered then start no read and change no result.
- R8: done is a single-cycle pulse, raised one cycle after the final mem_rd_valid of a load, with result valid in that cycle. A request offered during that cycle is accepted.
- R9: mem_rd_en is a single-cycle pulse for each read. The first read is issued in the cycle after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request offered |
| req_addr | input | ADDR_W | Byte address of the load |
| req_ready | output | 1 | Block idle and able to accept |
| mem_rd_en | output | 1 | Word read strobe to memory |
| mem_word_addr | output | ADDR_W-2 | Word index of the read |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Returned aligned word |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Merged load data |

## Verification
Completing one load and accepting the next can fall in the same cycle. Once the final data has been merged, the controller is idle again while done is high. The bench provokes this by keeping req_valid high across the end of an unaligned load and presenting a new address during the done cycle. It then judges that the first result is correct and that a read strobe for the new word index follows on the very next cycle. The new load must also finish with its own correct merged word.

// File: rtl/sl_pkg.sv
package sl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } sl_state_e;
endpackage

// File: rtl/sl_ctrl.sv
module sl_ctrl
  import sl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LANES  = 4,
  localparam int LOFF_W  = $clog2(LANES),
  localparam int WORD_AW = ADDR_W - LOFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               mem_rd_valid,
  output logic               req_ready,
  output logic               mem_rd_en,
  output logic [WORD_AW-1:0] mem_word_addr,
  output logic [LOFF_W-1:0]  lane_off,
  output logic               capture_first,
  output logic               finish,
  output logic               finish_second
);
  sl_state_e          state;
  logic [WORD_AW-1:0] base_word;

  assign req_ready     = (state == ST_IDLE);
  assign capture_first = (state == ST_FIRST) && mem_rd_valid && (lane_off != '0);
  assign finish_second = (state == ST_SECOND) && mem_rd_valid;
  assign finish        = finish_second ||
                         ((state == ST_FIRST) && mem_rd_valid && (lane_off == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      mem_rd_en     <= 1'b0;
      mem_word_addr <= '0;
      base_word     <= '0;
      lane_off      <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            base_word     <= req_addr[ADDR_W-1:LOFF_W];
            lane_off      <= req_addr[LOFF_W-1:0];
            mem_word_addr <= req_addr[ADDR_W-1:LOFF_W];
            mem_rd_en     <= 1'b1;
            state         <= ST_FIRST;
          end
        end
        ST_FIRST: begin
          if (mem_rd_valid) begin
            if (lane_off == '0) begin
              state <= ST_IDLE;
            end else begin
              mem_word_addr <= WORD_AW'(base_word + 1'b1);
              mem_rd_en     <= 1'b1;
              state         <= ST_SECOND;
            end
          end
        end
        ST_SECOND: begin
          if (mem_rd_valid) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Word index used by the first read of each load, kept for checking only
  logic [WORD_AW-1:0] first_q;
  always_ff @(posedge clk) begin
    if (rst) first_q <= '0;
    else if (mem_rd_en && state == ST_FIRST) first_q <= mem_word_addr;
  end

  a_r3_next_word: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && state == ST_SECOND) |-> mem_word_addr == WORD_AW'(first_q + 1'b1))
    else $error("R3: second read is not the next word index");

  a_r9_rd_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en)
    else $error("R9: read strobe longer than one cycle");

  a_r7_busy_quiet: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !mem_rd_valid) |=> !mem_rd_en)
    else $error("R7: read issued while waiting without returned data");
endmodule

// File: rtl/sl_rotator.sv
module sl_rotator #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int LOFF_W = $clog2(LANES),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic [DATA_W-1:0] din,
  input  logic [LOFF_W-1:0] shift,
  output logic [DATA_W-1:0] dout
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LOFF_W-1:0] src;
    assign src = LOFF_W'(j) + shift;
    assign dout[j*LANE_W +: LANE_W] = din[src*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/sl_merge.sv
module sl_merge #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int LOFF_W = $clog2(LANES),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rot_data,
  input  logic [LOFF_W-1:0] lane_off,
  input  logic              capture_first,
  input  logic              finish,
  input  logic              finish_second,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] hold;
  logic [DATA_W-1:0] merged;

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      if (j < LANES - int'(lane_off))
        merged[j*LANE_W +: LANE_W] = hold[j*LANE_W +: LANE_W];
      else
        merged[j*LANE_W +: LANE_W] = rot_data[j*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      result <= '0;
      hold   <= '0;
    end else begin
      done <= finish;
      if (capture_first) hold <= rot_data;
      if (finish) result <= finish_second ? merged : rot_data;
    end
  end

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done)
    else $error("R8: done longer than one cycle");

  a_r8_result_stable: assert property (@(posedge clk) disable iff (rst)
    (!done && !finish) |=> $stable(result))
    else $error("R8: result changed outside a completion");
endmodule

// File: rtl/split_load_merger.sv
module split_load_merger #(
  parameter int ADDR_W = 12,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int LOFF_W  = $clog2(LANES),
  localparam int WORD_AW = ADDR_W - LOFF_W,
  localparam int DATA_W  = LANES * LANE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               req_ready,
  output logic               mem_rd_en,
  output logic [WORD_AW-1:0] mem_word_addr,
  input  logic               mem_rd_valid,
  input  logic [DATA_W-1:0]  mem_rd_data,
  output logic               done,
  output logic [DATA_W-1:0]  result
);
  logic [LOFF_W-1:0] lane_off;
  logic              capture_first;
  logic              finish;
  logic              finish_second;
  logic [DATA_W-1:0] rot_data;

  sl_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) i_ctrl (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .mem_rd_valid  (mem_rd_valid),
    .req_ready     (req_ready),
    .mem_rd_en     (mem_rd_en),
    .mem_word_addr (mem_word_addr),
    .lane_off      (lane_off),
    .capture_first (capture_first),
    .finish        (finish),
    .finish_second (finish_second)
  );

  sl_rotator #(.LANES(LANES), .LANE_W(LANE_W)) i_rot (
    .din   (mem_rd_data),
    .shift (lane_off),
    .dout  (rot_data)
  );

  sl_merge #(.LANES(LANES), .LANE_W(LANE_W)) i_merge (
    .clk           (clk),
    .rst           (rst),
    .rot_data      (rot_data),
    .lane_off      (lane_off),
    .capture_first (capture_first),
    .finish        (finish),
    .finish_second (finish_second),
    .done          (done),
    .result        (result)
  );

  a_r8_done_after_data: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(mem_rd_valid))
    else $error("R8: done without returned data");

  a_r9_accept_issues: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> mem_rd_en)
    else $error("R9: accepted request did not issue a read");
endmodule

// File: tb/test_split_load_merger.sv
`timescale 1ns/1ps
module test_split_load_merger;
  localparam int ADDR_W  = 12;
  localparam int WORD_AW = ADDR_W - 2;
  localparam int AMASK   = (1 << ADDR_W) - 1;
  localparam int WMASK   = (1 << WORD_AW) - 1;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               req_valid = 1'b0;
  logic [ADDR_W-1:0]  req_addr = '0;
  logic               req_ready;
  logic               mem_rd_en;
  logic [WORD_AW-1:0] mem_word_addr;
  logic               mem_rd_valid = 1'b0;
  logic [31:0]        mem_rd_data = '0;
  logic               done;
  logic [31:0]        result;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  split_load_merger #(.ADDR_W(ADDR_W)) i_split_load_merger (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .mem_rd_en(mem_rd_en), .mem_word_addr(mem_word_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .done(done), .result(result)
  );

  function automatic logic [7:0] bval(int a);
    int m = a & AMASK;
    return 8'(m * 37 + (m >> 5) + 11);
  endfunction

  function automatic logic [31:0] wordv(int w);
    int b = (w & WMASK) * 4;
    return {bval(b + 3), bval(b + 2), bval(b + 1), bval(b)};
  endfunction

  function automatic logic [31:0] expv(int a);
    return {bval(a + 3), bval(a + 2), bval(a + 1), bval(a)};
  endfunction

  // Memory model: fixed two-cycle read latency
  logic               s1_v = 1'b0;
  logic [WORD_AW-1:0] s1_a = '0;
  int                 total_rd = 0;
  int                 rd_log [8];
  always @(posedge clk) begin
    s1_v         <= mem_rd_en && !rst;
    s1_a         <= mem_word_addr;
    mem_rd_valid <= s1_v;
    mem_rd_data  <= s1_v ? wordv(int'(s1_a)) : 32'hDEAD_BEEF;
    if (mem_rd_en && !rst) begin
      rd_log[total_rd % 8] <= int'(mem_word_addr);
      total_rd             <= total_rd + 1;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 30 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
  endtask

  task automatic run_load(int a, int nreads, string tag);
    int start;
    bit seen;
    start = total_rd;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = ADDR_W'(a);
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_rd_en == 1'b1, "R9", 32'(mem_rd_en), 32'd1);
    wait_done(seen);
    chk(seen, tag, 32'(seen), 32'd1);
    chk(result == expv(a), tag, result, expv(a));
    chk(total_rd - start == nreads, nreads == 1 ? "R2" : "R3",
        32'(total_rd - start), 32'(nreads));
    chk(rd_log[start % 8] == ((a >> 2) & WMASK), "R3",
        32'(rd_log[start % 8]), 32'((a >> 2) & WMASK));
    if (nreads == 2)
      chk(rd_log[(start + 1) % 8] == (((a >> 2) + 1) & WMASK), "R6",
          32'(rd_log[(start + 1) % 8]), 32'(((a >> 2) + 1) & WMASK));
    @(negedge clk);
    chk(done == 1'b0, "R8", 32'(done), 32'd0);
  endtask

  // Address in [15:4], expected read count in [3:0]
  localparam logic [15:0] VEC [12] = '{
    {12'h000, 4'd1}, {12'h004, 4'd1}, {12'h001, 4'd2}, {12'h002, 4'd2},
    {12'h003, 4'd2}, {12'h105, 4'd2}, {12'h2A6, 4'd2}, {12'h777, 4'd2},
    {12'hFFC, 4'd1}, {12'hFFD, 4'd2}, {12'hFFE, 4'd2}, {12'hFFF, 4'd2}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    bit seen;
    int start;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(req_ready == 1'b1, "R1", 32'(req_ready), 32'd1);
    chk(done == 1'b0, "R1", 32'(done), 32'd0);
    chk(mem_rd_en == 1'b0, "R1", 32'(mem_rd_en), 32'd0);

    // R2 R4 R5 R6 table walk
    for (int v = 0; v < 12; v++) begin
      int a = int'(VEC[v][15:4]);
      int n = int'(VEC[v][3:0]);
      string tag = (a & 3) == 0 ? "R2" : (a >= 12'hFFD ? "R6" : "R4/R5");
      run_load(a, n, tag);
    end

    // R7: request offered while busy is ignored
    start = total_rd;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 12'h005;
    @(negedge clk);
    req_addr = 12'h100;
    chk(req_ready == 1'b0, "R7", 32'(req_ready), 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(seen);
    chk(result == expv(12'h005), "R7", result, expv(12'h005));
    repeat (6) begin
      @(negedge clk);
      chk(done == 1'b0 && mem_rd_en == 1'b0, "R7", 32'({done, mem_rd_en}), 32'd0);
    end
    chk(total_rd - start == 2, "R7", 32'(total_rd - start), 32'd2);

    // R8: done and next acceptance in the same cycle
    @(negedge clk);
    req_valid = 1'b1; req_addr = 12'h011;
    @(negedge clk);
    wait_done(seen);
    chk(result == expv(12'h011), "R8", result, expv(12'h011));
    chk(req_ready == 1'b1, "R8", 32'(req_ready), 32'd1);
    req_addr = 12'h022;
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_rd_en == 1'b1 && mem_word_addr == WORD_AW'(12'h022 >> 2), "R9",
        32'(mem_word_addr), 32'(12'h022 >> 2));
    wait_done(seen);
    chk(seen && result == expv(12'h022), "R8", result, expv(12'h022));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule